// File: doc/BRIEF.md
# Inter-core cache pollution filter

One copy of this block sits beside each core's prefetcher in a shared last-level cache. It measures how much harm that core's prefetches do to the other cores. Whenever a prefetch issued by the watched core pushes out a demand line that belongs to another core, the victim's address is hashed into a small bit array. The entry at that index is marked as polluted and tagged with the victim's core id.

Demand misses from every core are looked up in the same array. A miss counts as pollution when it lands on a marked entry whose tag names the core that is now missing. Each such miss adds one to a saturating pollution count. Throttling logic reads the count once per sampling interval and clears it with a one-cycle pulse.

Top module: `pol_filter`

## Requirements
- R1: Index hash: the line address (ADDR_W bits, even) is split into upper and lower halves that are XORed together. The result is cut into IDX_W-bit chunks starting at bit 0, with the top chunk zero-padded, and the chunks are XORed to give the index. Defaults are ADDR_W=32 and IDX_W=10, so there are 1024 entries.
- R2: An eviction with `ev_valid_i`=1, `ev_pf_core_i`==CORE_ID and `ev_owner_i`!=CORE_ID marks the entry at hash(`ev_addr_i`) as polluted and stores `ev_owner_i` in it.
- R3: A demand miss whose entry is marked and whose stored owner equals `miss_core_i` raises `pol_count_o` by one on the clock edge that samples it. The new value is visible after that edge.
- R4: A miss on an unmarked entry, or on an entry tagged with a different core, leaves both the count and the entry unchanged.
- R5: A counting miss unmarks its entry, so a second miss on the same address does not count again.
- R6: When an eviction and a miss hit the same index in the same cycle, the miss is checked against the entry's previous contents. The eviction's mark and owner are then written.
- R7: `pol_count_o` saturates at all ones and stays there while further counting misses arrive.
- R8: `interval_end_i` sets the count to 0. If a counting miss arrives in the same cycle, the count becomes 1 instead.
- R9: Reset (`rst_ni` low) clears the count and unmarks every entry.
- R10: Evictions where `ev_pf_core_i`!=CORE_ID, or where `ev_owner_i`==CORE_ID, change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ev_valid_i | input | 1 | A prefetch eviction of a demand line occurs this cycle |
| ev_addr_i | input | ADDR_W | Line address of the evicted line |
| ev_pf_core_i | input | CORE_W | Core whose prefetch caused the eviction |
| ev_owner_i | input | CORE_W | Core that owned the evicted demand line |
| miss_valid_i | input | 1 | A demand miss occurs this cycle |
| miss_addr_i | input | ADDR_W | Line address of the missing line |
| miss_core_i | input | CORE_W | Core that missed |
| interval_end_i | input | 1 | Pulse that clears the count |
| pol_count_o | output | CNT_W | Saturating pollution count |

## Verification
The bench goes after the cases where a filter is most easily wrong:
- **Double counting.** A filter that does not unmark entries on a counting miss would report the same eviction twice.
- **Wrong core.** A filter that ignores the owner tag would charge misses from a core that was never harmed.
- **Same-index collision.** A collision handled in the wrong order would either lose the new mark or count against the new owner.
- **Counter limits.** A narrow counter is driven to its limit, so wrap-around would show as a drop to zero. It is also cleared while a counting miss arrives, which shows whether that miss is lost.
- **Hash aliasing.** Two addresses that fold to the same index check the hash.
- **Reset.** A mid-run reset shows whether old marks survive.

A long random phase over a small address pool mixes all of these cases.

// File: rtl/pol_pkg.sv
package pol_pkg;
  parameter int unsigned CORE_W = 2;
  typedef logic [CORE_W-1:0] core_id_t;
endpackage

// File: rtl/pol_hash.sv
module pol_hash #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int unsigned HALF   = ADDR_W / 2;
  localparam int unsigned NCHUNK = (HALF + IDX_W - 1) / IDX_W;
  localparam int unsigned PADW   = NCHUNK * IDX_W;

  logic [HALF-1:0] half_x;
  logic [PADW-1:0] padded;

  assign half_x = addr_i[HALF-1:0] ^ addr_i[ADDR_W-1:HALF];
  assign padded = PADW'(half_x);

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < int'(NCHUNK); k++) begin
      idx_o = idx_o ^ padded[k*IDX_W +: IDX_W];
    end
  end
endmodule

// File: rtl/pol_store.sv
module pol_store
  import pol_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_en_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  core_id_t         set_owner_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic             clr_en_i,
  output logic             rd_pol_o,
  output core_id_t         rd_owner_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic     pol_q   [DEPTH];
  core_id_t owner_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    // set wins over clear on the same index (miss resolved first)
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                   pol_q[g] <= 1'b0;
      else if (set_en_i && set_idx_i == IDX_W'(g))   pol_q[g] <= 1'b1;
      else if (clr_en_i && rd_idx_i == IDX_W'(g))    pol_q[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (set_en_i) owner_q[set_idx_i] <= set_owner_i;
  end

  assign rd_pol_o   = pol_q[rd_idx_i];
  assign rd_owner_o = owner_q[rd_idx_i];

  // R2
  set_marks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_en_i |=> pol_q[$past(set_idx_i)]);

  // R5
  hit_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_en_i && !(set_en_i && set_idx_i == rd_idx_i)) |=> !pol_q[$past(rd_idx_i)]);
endmodule

// File: rtl/pol_counter.sv
module pol_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             clr_i,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= inc_i ? CNT_W'(1) : '0;
    else if (inc_i && cnt_o != MAX) cnt_o <= cnt_o + 1'b1;
  end

  // R7
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_o == MAX && !clr_i) |=> cnt_o == MAX);

  // R4
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !clr_i) |=> $stable(cnt_o));

  // R8
  clr_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !inc_i) |=> cnt_o == '0);

  // R3
  no_decrease_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> cnt_o >= $past(cnt_o));
endmodule

// File: rtl/pol_filter.sv
module pol_filter
  import pol_pkg::*;
#(
  parameter int unsigned CORE_ID = 0,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned CNT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ev_valid_i,
  input  logic [ADDR_W-1:0] ev_addr_i,
  input  logic [CORE_W-1:0] ev_pf_core_i,
  input  logic [CORE_W-1:0] ev_owner_i,
  input  logic              miss_valid_i,
  input  logic [ADDR_W-1:0] miss_addr_i,
  input  logic [CORE_W-1:0] miss_core_i,
  input  logic              interval_end_i,
  output logic [CNT_W-1:0]  pol_count_o
);
  localparam core_id_t SELF = CORE_W'(CORE_ID);

  logic [IDX_W-1:0] ev_idx, miss_idx;
  logic             ev_take, rd_pol, hit;
  core_id_t         rd_owner;

  pol_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_hash_ev (
    .addr_i(ev_addr_i), .idx_o(ev_idx));
  pol_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) i_hash_miss (
    .addr_i(miss_addr_i), .idx_o(miss_idx));

  assign ev_take = ev_valid_i && ev_pf_core_i == SELF && ev_owner_i != SELF;
  assign hit     = miss_valid_i && rd_pol && rd_owner == miss_core_i;

  pol_store #(.IDX_W(IDX_W)) i_store (
    .clk_i, .rst_ni,
    .set_en_i(ev_take), .set_idx_i(ev_idx), .set_owner_i(ev_owner_i),
    .rd_idx_i(miss_idx), .clr_en_i(hit),
    .rd_pol_o(rd_pol), .rd_owner_o(rd_owner));

  pol_counter #(.CNT_W(CNT_W)) i_cnt (
    .clk_i, .rst_ni, .inc_i(hit), .clr_i(interval_end_i), .cnt_o(pol_count_o));

  // R10
  self_never_hits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_valid_i && miss_core_i == SELF) |-> !hit);
endmodule

// File: tb/test_pol_filter.sv
module test_pol_filter;
  localparam int ADDR_W = 32, IDX_W = 10, CNT_W = 4, CID = 1;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MAXC = (1 << CNT_W) - 1;

  logic clk = 0, rst_ni = 0;
  logic ev_valid = 0, miss_valid = 0, iend = 0;
  logic [ADDR_W-1:0] ev_addr = 0, miss_addr = 0;
  logic [1:0] ev_pf = 0, ev_own = 0, miss_core = 0;
  logic [CNT_W-1:0] cnt;

  int checks = 0, fails = 0;
  bit done = 0;
  bit mpol [DEPTH];
  logic [1:0] mown [DEPTH];
  int mcnt = 0;

  always #5 clk = ~clk;

  pol_filter #(.CORE_ID(CID), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) i_pol_filter (
    .clk_i(clk), .rst_ni, .ev_valid_i(ev_valid), .ev_addr_i(ev_addr),
    .ev_pf_core_i(ev_pf), .ev_owner_i(ev_own), .miss_valid_i(miss_valid),
    .miss_addr_i(miss_addr), .miss_core_i(miss_core), .interval_end_i(iend),
    .pol_count_o(cnt));

  // R1 reference hash
  function automatic int hidx(logic [ADDR_W-1:0] a);
    logic [15:0] h = a[15:0] ^ a[31:16];
    int r = 0;
    for (int b = 0; b < 16; b++) r ^= int'(h[b]) << (b % IDX_W);
    return r;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(bit ev, logic [31:0] ea, logic [1:0] pf, logic [1:0] own,
                     bit mv, logic [31:0] ma, logic [1:0] mc, bit ie, string tag);
    bit hit;
    int hm, he;
    @(negedge clk);
    ev_valid = ev; ev_addr = ea; ev_pf = pf; ev_own = own;
    miss_valid = mv; miss_addr = ma; miss_core = mc; iend = ie;
    hm = hidx(ma); he = hidx(ea);
    hit = mv && mpol[hm] && mown[hm] == mc;
    if (hit) mpol[hm] = 0;
    if (ev && pf == 2'(CID) && own != 2'(CID)) begin mpol[he] = 1; mown[he] = own; end
    if (ie) mcnt = hit ? 1 : 0;
    else if (hit && mcnt < MAXC) mcnt++;
    @(posedge clk); #1;
    chk(tag, int'(cnt), mcnt);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_ni = 0;
    ev_valid = 0; miss_valid = 0; iend = 0;
    for (int i = 0; i < DEPTH; i++) mpol[i] = 0;
    mcnt = 0;
    @(negedge clk); chk("R9 count in reset", int'(cnt), 0);
    rst_ni = 1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] a, b, pool [16];
    void'($urandom(32'h5eed));
    do_reset();
    a = 32'h1234_5678;
    b = a ^ 32'h0001_0001; // same index (R1 alias)
    cyc(0,0,0,0, 1,a,2, 0, "R9 miss after reset");
    cyc(1,a,1,2, 0,0,0, 0, "R2 evict");
    cyc(0,0,0,0, 1,a,3, 0, "R4 wrong core");
    cyc(0,0,0,0, 1,a,2, 0, "R3 count");
    cyc(0,0,0,0, 1,a,2, 0, "R5 once");
    cyc(1,a,0,2, 0,0,0, 0, "R10 other pf core");
    cyc(1,a,1,1, 0,0,0, 0, "R10 self owner");
    cyc(0,0,0,0, 1,a,2, 0, "R10 ignored ev");
    cyc(0,0,0,0, 1,a,1, 0, "R10 self miss");
    cyc(1,a,1,3, 0,0,0, 0, "R2 evict owner3");
    cyc(0,0,0,0, 1,b,3, 0, "R1 alias hit");
    cyc(1,a,1,2, 0,0,0, 0, "R6 setup");
    cyc(1,a,1,3, 1,a,2, 0, "R6 same idx miss first");
    cyc(0,0,0,0, 1,a,3, 0, "R6 new owner");
    cyc(0,0,0,0, 0,0,0, 1, "R8 clear");
    cyc(1,a,1,0, 0,0,0, 0, "R8 setup");
    cyc(0,0,0,0, 1,a,0, 1, "R8 clear with hit");
    for (int i = 0; i < 20; i++) begin
      cyc(1,a,1,2, 0,0,0, 0, "R7 setup");
      cyc(0,0,0,0, 1,a,2, 0, "R7 saturate");
    end
    chk("R7 at max", int'(cnt), MAXC);
    cyc(1,a,1,2, 0,0,0, 0, "R9 pre-reset evict");
    do_reset();
    cyc(0,0,0,0, 1,a,2, 0, "R9 bits cleared");
    for (int i = 0; i < 16; i++) pool[i] = $urandom;
    for (int i = 0; i < 4000; i++)
      cyc($urandom_range(0,1), pool[$urandom_range(0,15)], 2'($urandom_range(0,3)),
          2'($urandom_range(0,3)), $urandom_range(0,1), pool[$urandom_range(0,15)],
          2'($urandom_range(0,3)), $urandom_range(0,63) == 0, "R3 random");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule